// File: doc/BRIEF.md
# Standby stop-mode power sequencer

This block sequences the low-power states of a small microcontroller. The CPU sends a one-cycle stop request. The block checks which clock the CPU is running from and whether any interrupt is already waiting. It then either parks the chip in STOP or goes at once to the wake path. On wake it holds the CPU clock off until the main oscillator has had a programmable number of reference cycles to settle.

Its outputs are plain enables. There is one each for the main crystal oscillator, the CPU clock and the ring oscillator, plus one gate per peripheral clock. It also reports the current power mode. The oscillators, the CPU and the peripherals sit outside this block. Wake sources arrive as request and mask vectors. Peripheral clock selections arrive as status bits.

The state machine has four states, each named after the mode it reports:
- RUN (`2'b00`): the CPU is clocked.
- HALT (`2'b01`): a one-cycle pass-through, taken when a stop request meets an interrupt that is already pending.
- STOP (`2'b10`): the oscillators and the CPU clock are parked.
- WAIT (`2'b11`): oscillator stabilization is in progress.

The transitions are:
- RUN→STOP: an accepted request with no pending interrupt.
- RUN→HALT: an accepted request while an interrupt is pending.
- HALT→WAIT: always, after one cycle.
- STOP→WAIT: a pending unmasked interrupt.
- WAIT→RUN: the stabilization count has expired.

Top module: `stdby_seq`

## Requirements
- R1: A stop request is accepted only while `cpu_src` is `2'b00` (main crystal) or `2'b01` (ring oscillator). With `2'b10` or `2'b11` the request is ignored and the mode stays RUN.
- R2: A wake source is any bit `i` where `irq_req[i]=1` and `irq_mask[i]=0`. In STOP, a wake source moves the block to WAIT on the next cycle. Requests whose mask bit is set leave STOP unchanged.
- R3: An accepted stop request that arrives while a wake source is present gives HALT for exactly one cycle, followed by WAIT.
- R4: WAIT lasts exactly 2^E cycles and then the block returns to RUN. E is chosen by `stab_sel`, which is sampled on entry to WAIT: code 0→E0, 1→E1, 2→E2, 3→E3, 4→E4, and codes 5 to 7 also use E4. The defaults are 11, 13, 14, 15 and 16. The count restarts from zero on every entry to WAIT.
- R5: `x1_en` is 0 in STOP and 1 in every other mode. `cpu_clk_en` is 1 only in RUN.
- R6: `ring_en` is 0 only in STOP, and only when `ring_may_stop=1` and the stop was entered from the main crystal (`cpu_src=2'b00`). Otherwise it is 1.
- R7: In STOP, `tmr_clk_en[i]` equals `tmr_ext_sel[i]` and `sio_clk_en` equals `sio_ext_sel`. Outside STOP these gates are 1.
- R8: In STOP, `wt_clk_en` equals `wt_sub_sel & sub_clk_on`. Outside STOP it is 1.
- R9: `mode` reports RUN=`00`, HALT=`01`, STOP=`10` and WAIT=`11`. After reset the mode is RUN and every enable is 1.
- R10: A stop request during HALT, STOP or WAIT has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock, active during the stabilization wait |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | One-cycle stop request from the CPU |
| cpu_src | input | 2 | Current CPU clock source: 00 crystal, 01 ring, 10 subsystem, 11 reserved |
| irq_req | input | NIRQ | Interrupt request flags |
| irq_mask | input | NIRQ | Interrupt mask flags (1 = masked) |
| stab_sel | input | 3 | Stabilization length code |
| ring_may_stop | input | 1 | Configuration: ring oscillator may be stopped |
| tmr_ext_sel | input | NTMR | Each timer counts from its external input |
| sio_ext_sel | input | 1 | Serial interface uses an external shift clock |
| wt_sub_sel | input | 1 | Watch timer selects the subsystem clock |
| sub_clk_on | input | 1 | Subsystem clock is in use |
| x1_en | output | 1 | Main crystal oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| ring_en | output | 1 | Ring oscillator enable |
| tmr_clk_en | output | NTMR | Timer clock gates |
| sio_clk_en | output | 1 | Serial interface clock gate |
| wt_clk_en | output | 1 | Watch timer clock gate |
| mode | output | 2 | Current power mode |

## Verification
A wrong state register shows up on `mode` and on every enable in the very cycle after the bad transition, so comparing against the model each cycle pins the fault to a single edge.

Faults in the stabilization counter stay hidden until WAIT ends. They then appear as a return to RUN one or more cycles early or late. The bench therefore measures the length of every WAIT interval at the ports and checks it against the selected code.

A wrong latched entry source is visible only through `ring_en` while in STOP. The bench therefore enters STOP from both allowed sources, with `ring_may_stop` both set and clear.

// File: rtl/stdby_pkg.sv
package stdby_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_HALT = 2'b01,
        MODE_STOP = 2'b10,
        MODE_WAIT = 2'b11
    } pmode_e;

    typedef enum logic [1:0] {
        CSRC_X1   = 2'b00,
        CSRC_RING = 2'b01,
        CSRC_SUB  = 2'b10,
        CSRC_RSV  = 2'b11
    } csrc_e;

endpackage

// File: rtl/stdby_wake_det.sv
module stdby_wake_det #(
    parameter int NIRQ = 8
) (
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_mask,
    output logic            wake
);

    logic [NIRQ-1:0] live;

    for (genvar i = 0; i < NIRQ; i++) begin : g_src
        assign live[i] = irq_req[i] & ~irq_mask[i];
    end

    assign wake = |live;

endmodule

// File: rtl/stdby_stab_timer.sv
module stdby_stab_timer #(
    parameter int E0 = 11,
    parameter int E1 = 13,
    parameter int E2 = 14,
    parameter int E3 = 15,
    parameter int E4 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       done
);

    localparam int CW = E4 + 1;

    logic [2:0]    sel_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            sel_q <= sel;
            cnt_q <= '0;
        end else if (run && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        unique case (sel_q)
            3'd0:    last = CW'((64'd1 << E0) - 64'd1);
            3'd1:    last = CW'((64'd1 << E1) - 64'd1);
            3'd2:    last = CW'((64'd1 << E2) - 64'd1);
            3'd3:    last = CW'((64'd1 << E3) - 64'd1);
            default: last = CW'((64'd1 << E4) - 64'd1);
        endcase
    end

    assign done = run && (cnt_q == last);

    AST_WAIT_COUNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R4

    AST_COUNT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !done && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4

endmodule

// File: rtl/stdby_gate_ctrl.sv
module stdby_gate_ctrl #(
    parameter int NTMR = 2
) (
    input  logic            in_stop,
    input  logic [NTMR-1:0] tmr_ext_sel,
    input  logic            sio_ext_sel,
    input  logic            wt_sub_sel,
    input  logic            sub_clk_on,
    output logic [NTMR-1:0] tmr_clk_en,
    output logic            sio_clk_en,
    output logic            wt_clk_en
);

    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
        assign tmr_clk_en[i] = !in_stop || tmr_ext_sel[i];
    end

    assign sio_clk_en = !in_stop || sio_ext_sel;
    assign wt_clk_en  = !in_stop || (wt_sub_sel && sub_clk_on);

endmodule

// File: rtl/stdby_seq.sv
module stdby_seq
    import stdby_pkg::*;
#(
    parameter int NIRQ = 8,
    parameter int NTMR = 2,
    parameter int E0   = 11,
    parameter int E1   = 13,
    parameter int E2   = 14,
    parameter int E3   = 15,
    parameter int E4   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stop_req,
    input  logic [1:0]      cpu_src,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_mask,
    input  logic [2:0]      stab_sel,
    input  logic            ring_may_stop,
    input  logic [NTMR-1:0] tmr_ext_sel,
    input  logic            sio_ext_sel,
    input  logic            wt_sub_sel,
    input  logic            sub_clk_on,
    output logic            x1_en,
    output logic            cpu_clk_en,
    output logic            ring_en,
    output logic [NTMR-1:0] tmr_clk_en,
    output logic            sio_clk_en,
    output logic            wt_clk_en,
    output logic [1:0]      mode
);

    pmode_e st_q, st_d;
    logic   src_x1_q;
    logic   wake;
    logic   stop_ok;
    logic   enter_wait;
    logic   stab_done;

    stdby_wake_det #(.NIRQ(NIRQ)) u_wake (
        .irq_req  (irq_req),
        .irq_mask (irq_mask),
        .wake     (wake)
    );

    stdby_stab_timer #(.E0(E0), .E1(E1), .E2(E2), .E3(E3), .E4(E4)) u_stab (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (enter_wait),
        .run   (st_q == MODE_WAIT),
        .sel   (stab_sel),
        .done  (stab_done)
    );

    stdby_gate_ctrl #(.NTMR(NTMR)) u_gate (
        .in_stop     (st_q == MODE_STOP),
        .tmr_ext_sel (tmr_ext_sel),
        .sio_ext_sel (sio_ext_sel),
        .wt_sub_sel  (wt_sub_sel),
        .sub_clk_on  (sub_clk_on),
        .tmr_clk_en  (tmr_clk_en),
        .sio_clk_en  (sio_clk_en),
        .wt_clk_en   (wt_clk_en)
    );

    assign stop_ok = stop_req &&
                     (cpu_src == CSRC_X1 || cpu_src == CSRC_RING);

    assign enter_wait = (st_q == MODE_HALT) ||
                        (st_q == MODE_STOP && wake);

    // Next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MODE_RUN:  if (stop_ok) st_d = wake ? MODE_HALT : MODE_STOP;
            MODE_HALT: st_d = MODE_WAIT;
            MODE_STOP: if (wake) st_d = MODE_WAIT;
            MODE_WAIT: if (stab_done) st_d = MODE_RUN;
            default:   st_d = MODE_RUN;
        endcase
    end

    // State register and entry-source latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= MODE_RUN;
            src_x1_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == MODE_RUN && stop_ok) begin
                src_x1_q <= (cpu_src == CSRC_X1);
            end
        end
    end

    // Outputs
    always_comb begin
        x1_en      = 1'b1;
        cpu_clk_en = 1'b0;
        ring_en    = 1'b1;
        unique case (st_q)
            MODE_RUN:  cpu_clk_en = 1'b1;
            MODE_HALT: cpu_clk_en = 1'b0;
            MODE_STOP: begin
                x1_en   = 1'b0;
                ring_en = !(ring_may_stop && src_x1_q);
            end
            MODE_WAIT: cpu_clk_en = 1'b0;
            default:   cpu_clk_en = 1'b1;
        endcase
        mode = st_q;
    end

    AST_STOP_SOURCE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MODE_RUN && stop_req && cpu_src[1]) |=> (st_q == MODE_RUN)); // R1

    AST_WAKE_LEAVES_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MODE_STOP && wake) |=> (st_q == MODE_WAIT)); // R2

    AST_HALT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MODE_HALT) |=> (st_q == MODE_WAIT)); // R3

    AST_STOP_PARKS_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MODE_STOP) |-> (!x1_en && !cpu_clk_en)); // R5

    AST_RING_FROM_RING_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MODE_RUN && stop_req && cpu_src == CSRC_RING && !wake)
        |=> ring_en); // R6

    AST_WAIT_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == MODE_WAIT && stop_req && !stab_done) |=> (st_q == MODE_WAIT)); // R10

endmodule

// File: tb/stdby_seq_tb.sv
module stdby_seq_tb;

    localparam int NIRQ = 4;
    localparam int NTMR = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            stop_req = 1'b0;
    logic [1:0]      cpu_src = 2'b00;
    logic [NIRQ-1:0] irq_req = '0;
    logic [NIRQ-1:0] irq_mask = '1;
    logic [2:0]      stab_sel = 3'd0;
    logic            ring_may_stop = 1'b0;
    logic [NTMR-1:0] tmr_ext_sel = '0;
    logic            sio_ext_sel = 1'b0;
    logic            wt_sub_sel = 1'b0;
    logic            sub_clk_on = 1'b0;
    logic            x1_en, cpu_clk_en, ring_en, sio_clk_en, wt_clk_en;
    logic [NTMR-1:0] tmr_clk_en;
    logic [1:0]      mode;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string phase = "R9";

    always #10 clk = ~clk;

    stdby_seq #(.NIRQ(NIRQ), .NTMR(NTMR), .E0(2), .E1(3), .E2(4), .E3(5), .E4(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .cpu_src(cpu_src),
        .irq_req(irq_req), .irq_mask(irq_mask), .stab_sel(stab_sel),
        .ring_may_stop(ring_may_stop), .tmr_ext_sel(tmr_ext_sel),
        .sio_ext_sel(sio_ext_sel), .wt_sub_sel(wt_sub_sel), .sub_clk_on(sub_clk_on),
        .x1_en(x1_en), .cpu_clk_en(cpu_clk_en), .ring_en(ring_en),
        .tmr_clk_en(tmr_clk_en), .sio_clk_en(sio_clk_en), .wt_clk_en(wt_clk_en),
        .mode(mode)
    );

    // Behavioural reference model: 0 RUN, 1 HALT, 2 STOP, 3 WAIT
    int m_mode = 0;
    int m_cnt = 0;
    int m_len = 0;
    bit m_src_x1 = 0;

    function automatic int wait_len(input logic [2:0] s);
        case (s)
            3'd0: return 4;
            3'd1: return 8;
            3'd2: return 16;
            3'd3: return 32;
            default: return 64;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 0; m_len = 0; m_src_x1 = 0;
        end else begin
            bit pend;
            pend = |(irq_req & ~irq_mask);
            case (m_mode)
                0: if (stop_req && (cpu_src == 2'b00 || cpu_src == 2'b01)) begin
                       m_src_x1 = (cpu_src == 2'b00);
                       m_mode = pend ? 1 : 2;
                   end
                1: begin m_mode = 3; m_cnt = 0; m_len = wait_len(stab_sel); end
                2: if (pend) begin m_mode = 3; m_cnt = 0; m_len = wait_len(stab_sel); end
                default: if (m_cnt == m_len - 1) m_mode = 0; else m_cnt++;
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    int seen_wait = 0;
    int exp_wait = 0;
    always @(negedge clk) begin
        #5;
        if (!finished) begin
            bit stp;
            stp = (m_mode == 2);
            chk({phase, " mode"}, mode, m_mode);
            chk("R5 cpu_clk_en", cpu_clk_en, m_mode == 0);
            chk("R5 x1_en", x1_en, !stp);
            chk("R6 ring_en", ring_en, !(stp && ring_may_stop && m_src_x1));
            for (int i = 0; i < NTMR; i++)
                chk("R7 tmr_clk_en", tmr_clk_en[i], !stp || tmr_ext_sel[i]);
            chk("R7 sio_clk_en", sio_clk_en, !stp || sio_ext_sel);
            chk("R8 wt_clk_en", wt_clk_en, !stp || (wt_sub_sel && sub_clk_on));
            if (mode == 2'b11) begin
                if (seen_wait == 0) exp_wait = m_len;
                seen_wait++;
            end else if (seen_wait != 0) begin
                chk("R4 wait length", seen_wait, exp_wait);
                seen_wait = 0;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_stop(input logic [1:0] src);
        @(negedge clk);
        cpu_src = src; stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
    endtask

    task automatic wake_now;
        @(negedge clk);
        irq_mask = 4'b1011; irq_req = 4'b0100;
        @(negedge clk);
        irq_req = '0; irq_mask = '1;
    endtask

    task automatic until_run;
        for (int k = 0; k < 200 && m_mode != 0; k++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        phase = "R1";
        pulse_stop(2'b10); idle(3);
        pulse_stop(2'b11); idle(3);

        phase = "R2";
        pulse_stop(2'b00); idle(2);
        tmr_ext_sel = 2'b01; sio_ext_sel = 1'b1; idle(2);
        wt_sub_sel = 1'b1; idle(1); sub_clk_on = 1'b1; idle(2);
        irq_req = 4'b1111; irq_mask = 4'b1111; idle(3);
        irq_req = '0;
        phase = "R10";
        pulse_stop(2'b00); idle(2);
        phase = "R2";
        wake_now; until_run; idle(2);

        phase = "R3";
        stab_sel = 3'd2;
        irq_mask = 4'b1110; irq_req = 4'b0001;
        pulse_stop(2'b01);
        irq_req = '0; irq_mask = '1;
        phase = "R10";
        idle(3); pulse_stop(2'b00);
        until_run; idle(2);

        phase = "R6";
        ring_may_stop = 1'b1; tmr_ext_sel = 2'b10; sio_ext_sel = 1'b0; sub_clk_on = 1'b0;
        pulse_stop(2'b00); idle(3); wake_now; until_run;
        pulse_stop(2'b01); idle(3); wake_now; until_run; idle(2);

        phase = "R4";
        for (int c = 0; c < 8; c++) begin
            stab_sel = 3'(c);
            pulse_stop(c[0] ? 2'b01 : 2'b00); idle(2);
            wake_now; until_run; idle(2);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule